// File: doc/BRIEF.md
# Horizontal Scrolling Text Engine

This block produces a message that scrolls sideways across a dot-matrix panel. The panel has `ROWS` rows and `COLS` columns. Every pulse on the step input builds the next frame in a hidden back buffer. That frame is the current picture moved one column to the left, with a freshly generated column placed at the right-hand edge.

Fresh columns come from a 5-wide by 7-tall, one-bit-per-pixel glyph table. The table is indexed by the character codes the engine fetches from an external message memory. After the five glyph columns of each character, the engine adds one empty gap column. When the last character of the message has been fed, the engine starts again at the first character.

The hidden frame only becomes visible during the panel's blanking interval, when the two buffers exchange roles. The panel scan logic therefore never sees a half-built picture. The scan logic reads the visible frame one column at a time through a combinational read port. A step pulse that arrives while the previous frame is still waiting for blanking is kept and served next.

Top module: `scroll_text_engine`

## Requirements
- R1: While reset is asserted and after it is released, every column of the visible frame reads zero, `swap_o` is low and `str_addr_o` is 0, so the first step feeds column 0 of character 0.
- R2: Each step yields a new visible frame in which column index c (0 = leftmost) holds what column c+1 held before. Column `COLS-1` holds the newly generated column. Bit r of a column is glyph row r, with row 0 at the top. Rows at index 7 and above stay zero.
- R3: The visible frame changes only on a clock edge at which `blank_i` is high, and at no other time. `swap_o` is high for exactly the one cycle after that edge, which is also the first cycle in which the new frame is readable. A step accepted in the idle state is swapped in at the first later edge with `blank_i` high.
- R4: The generated column stream gives the five glyph columns of a character, left to right, followed by one all-zero gap column, so each character takes six steps.
- R5: `str_addr_o` gives the index of the character currently being fed. After the gap column of character `msg_len_i-1`, it returns to 0.
- R6: A step pulse that arrives while a frame is waiting for its swap is held, and it produces its own frame after that swap. One step can be held at a time.
- R7: Built-in glyphs, listed as column 0..4 in hex: space = 00,00,00,00,00; 'H' (0x48) = 7F,08,08,08,7F; 'I' (0x49) = 00,41,7F,41,00; '1' (0x31) = 00,42,7F,40,00; '-' (0x2D) = 08,08,08,08,08.
- R8: Any other printable code (0x20..0x7E) is drawn as an outline box: 7F,41,41,41,7F.
- R9: Codes below 0x20 or above 0x7E are drawn as five all-zero columns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | One-cycle scroll-step tick |
| blank_i | input | 1 | High while the panel is blanked; swaps happen only then |
| msg_len_i | input | $clog2(MSG_DEPTH+1) | Number of characters in the message |
| str_addr_o | output | max(1,$clog2(MSG_DEPTH)) | Message memory read address |
| str_data_i | input | 8 | Character code at `str_addr_o`, combinational |
| disp_col_i | input | $clog2(COLS) | Visible-frame column to read |
| disp_data_o | output | ROWS | Pixels of the addressed column |
| swap_o | output | 1 | One-cycle pulse after a buffer swap |

## Verification
A fault in the column counter or the character counter shows at the port within a single step. The right-hand column of the next swapped frame then holds the wrong pixels, or `str_addr_o` disagrees with the model after the sixth step of a character. A bad buffer select shows in the cycle right after a swap, because the frame read back is either the old picture or a stale back buffer. A lost pending step leaves one frame missing: the expected-frame queue is still not empty a few blanking periods later. A swap outside blanking shows on the very edge it happens, as a `swap_o` pulse that follows a cycle with `blank_i` low.

// File: rtl/scroll_pkg.sv
`timescale 1ns/1ps
package scroll_pkg;
   localparam int GLYPH_COLS = 5;
   localparam int GLYPH_ROWS = 7;
   localparam int SLOT_COLS  = GLYPH_COLS + 1;
   localparam int SLOT_W     = $clog2(SLOT_COLS);

   typedef enum logic {
      ENG_IDLE = 1'b0,
      ENG_WAIT = 1'b1
   } eng_state_e;
endpackage

// File: rtl/scroll_glyph_rom.sv
`timescale 1ns/1ps
module scroll_glyph_rom
   import scroll_pkg::*;
#(
   parameter int ROWS = 8
) (
   input  logic [7:0]        code_i,
   input  logic [SLOT_W-1:0] col_i,
   output logic [ROWS-1:0]   col_o
);
   // five 7-bit columns packed, column k at bits [k*7 +: 7]
   logic [GLYPH_COLS*GLYPH_ROWS-1:0] shape;
   logic [GLYPH_ROWS-1:0]            g;

   always_comb begin
      if (code_i < 8'h20 || code_i > 8'h7E) begin
         shape = '0;
      end else begin
         case (code_i)
            8'h20:   shape = '0;
            8'h48:   shape = {7'h7F, 7'h08, 7'h08, 7'h08, 7'h7F};
            8'h49:   shape = {7'h00, 7'h41, 7'h7F, 7'h41, 7'h00};
            8'h31:   shape = {7'h00, 7'h40, 7'h7F, 7'h42, 7'h00};
            8'h2D:   shape = {5{7'h08}};
            default: shape = {7'h7F, 7'h41, 7'h41, 7'h41, 7'h7F};
         endcase
      end
   end

   always_comb begin
      case (col_i)
         3'd0:    g = shape[6:0];
         3'd1:    g = shape[13:7];
         3'd2:    g = shape[20:14];
         3'd3:    g = shape[27:21];
         3'd4:    g = shape[34:28];
         default: g = '0;
      endcase
   end

   generate
      if (ROWS < GLYPH_ROWS) begin : g_rows_bad
         $error("scroll_glyph_rom: ROWS must be at least 7");
      end else if (ROWS == GLYPH_ROWS) begin : g_rows_exact
         assign col_o = g;
      end else begin : g_rows_pad
         assign col_o = {{(ROWS-GLYPH_ROWS){1'b0}}, g};
      end
   endgenerate
endmodule

// File: rtl/scroll_col_stream.sv
`timescale 1ns/1ps
module scroll_col_stream
   import scroll_pkg::*;
#(
   parameter int MSG_DEPTH = 16,
   parameter int AW        = 4,
   parameter int LW        = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   input  logic [LW-1:0]     msg_len_i,
   output logic [AW-1:0]     char_idx_o,
   output logic [SLOT_W-1:0] slot_col_o,
   output logic              spacer_o
);
   logic [AW-1:0]     ci_q;
   logic [SLOT_W-1:0] cc_q;
   logic [LW:0]       ci_next;
   logic              last_char;

   assign ci_next   = (LW+1)'(ci_q) + 1'b1;
   assign last_char = ci_next >= {1'b0, msg_len_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ci_q <= '0;
         cc_q <= '0;
      end else if (adv_i) begin
         if (cc_q == SLOT_W'(SLOT_COLS-1)) begin
            cc_q <= '0;
            ci_q <= last_char ? '0 : ci_q + 1'b1;
         end else begin
            cc_q <= cc_q + 1'b1;
         end
      end
   end

   assign char_idx_o = ci_q;
   assign slot_col_o = cc_q;
   assign spacer_o   = (cc_q == SLOT_W'(GLYPH_COLS));

   generate
      if (MSG_DEPTH < 1) begin : g_depth_bad
         $error("scroll_col_stream: MSG_DEPTH must be at least 1");
      end
   endgenerate
endmodule

// File: rtl/scroll_frame_store.sv
`timescale 1ns/1ps
module scroll_frame_store #(
   parameter int ROWS = 8,
   parameter int COLS = 16,
   parameter int CW   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            render_i,
   input  logic            swap_i,
   input  logic [ROWS-1:0] new_col_i,
   input  logic [CW-1:0]   rd_col_i,
   output logic [ROWS-1:0] rd_data_o
);
   logic            sel_q;   // 0: bank_a visible, 1: bank_b visible
   logic [ROWS-1:0] bank_a  [COLS];
   logic [ROWS-1:0] bank_b  [COLS];
   logic [ROWS-1:0] front   [COLS];
   logic [ROWS-1:0] shifted [COLS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= 1'b0;
      else if (swap_i) sel_q <= ~sel_q;
   end

   generate
      for (genvar c = 0; c < COLS; c++) begin : g_col
         assign front[c] = sel_q ? bank_b[c] : bank_a[c];
         if (c == COLS-1) begin : g_tail
            assign shifted[c] = new_col_i;
         end else begin : g_body
            assign shifted[c] = front[c+1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bank_a[c] <= '0;
               bank_b[c] <= '0;
            end else if (render_i) begin
               if (sel_q) bank_a[c] <= shifted[c];
               else       bank_b[c] <= shifted[c];
            end
         end
      end

      if (COLS == (1 << CW)) begin : g_rd_full
         assign rd_data_o = front[rd_col_i];
      end else begin : g_rd_guard
         assign rd_data_o = (int'(rd_col_i) < COLS) ? front[rd_col_i] : '0;
      end

      if (COLS < 2) begin : g_cols_bad
         $error("scroll_frame_store: COLS must be at least 2");
      end
   endgenerate
endmodule

// File: rtl/scroll_text_engine.sv
`timescale 1ns/1ps
module scroll_text_engine
   import scroll_pkg::*;
#(
   parameter  int ROWS      = 8,
   parameter  int COLS      = 16,
   parameter  int MSG_DEPTH = 16,
   localparam int CW        = $clog2(COLS),
   localparam int AW        = (MSG_DEPTH > 1) ? $clog2(MSG_DEPTH) : 1,
   localparam int LW        = $clog2(MSG_DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_i,
   input  logic            blank_i,
   input  logic [LW-1:0]   msg_len_i,
   output logic [AW-1:0]   str_addr_o,
   input  logic [7:0]      str_data_i,
   input  logic [CW-1:0]   disp_col_i,
   output logic [ROWS-1:0] disp_data_o,
   output logic            swap_o
);
   eng_state_e        state_q;
   logic              pend_q;
   logic              swap_q;
   logic              render;
   logic              swap;
   logic [SLOT_W-1:0] slot_col;
   logic              spacer;
   logic [ROWS-1:0]   glyph_col;
   logic [ROWS-1:0]   new_col;

   assign render = (state_q == ENG_IDLE) && (step_i || pend_q);
   assign swap   = (state_q == ENG_WAIT) && blank_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         pend_q  <= 1'b0;
         swap_q  <= 1'b0;
      end else begin
         swap_q <= swap;
         case (state_q)
            ENG_IDLE: if (render) state_q <= ENG_WAIT;
            ENG_WAIT: if (swap)   state_q <= ENG_IDLE;
            default:              state_q <= ENG_IDLE;
         endcase
         if (render)      pend_q <= step_i && pend_q;
         else if (step_i) pend_q <= 1'b1;
      end
   end

   scroll_col_stream #(
      .MSG_DEPTH (MSG_DEPTH),
      .AW        (AW),
      .LW        (LW)
   ) u_stream (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv_i      (render),
      .msg_len_i  (msg_len_i),
      .char_idx_o (str_addr_o),
      .slot_col_o (slot_col),
      .spacer_o   (spacer)
   );

   scroll_glyph_rom #(
      .ROWS (ROWS)
   ) u_rom (
      .code_i (str_data_i),
      .col_i  (slot_col),
      .col_o  (glyph_col)
   );

   assign new_col = spacer ? '0 : glyph_col;

   scroll_frame_store #(
      .ROWS (ROWS),
      .COLS (COLS),
      .CW   (CW)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .render_i  (render),
      .swap_i    (swap),
      .new_col_i (new_col),
      .rd_col_i  (disp_col_i),
      .rd_data_o (disp_data_o)
   );

   assign swap_o = swap_q;

   generate
      if (CW < 1) begin : g_cw_bad
         $error("scroll_text_engine: COLS must be at least 2");
      end
   endgenerate
endmodule

// File: rtl/scroll_text_engine_chk.sv
`timescale 1ns/1ps
module scroll_text_engine_chk #(
   parameter int ROWS = 8,
   parameter int CW   = 4,
   parameter int AW   = 4,
   parameter int LW   = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            blank_i,
   input logic            swap_o,
   input logic [CW-1:0]   disp_col_i,
   input logic [ROWS-1:0] disp_data_o,
   input logic [AW-1:0]   str_addr_o,
   input logic [LW-1:0]   msg_len_i
);
   // R3: a swap is only ever taken on an edge inside blanking
   a_r3_swap_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
      swap_o |-> $past(blank_i));

   // R3: swap flag is a single-cycle pulse
   a_r3_swap_single: assert property (@(posedge clk) disable iff (!rst_n)
      swap_o |=> !swap_o);

   // R3: visible frame holds still unless a swap just happened
   a_r3_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!swap_o && $stable(disp_col_i)) |-> $stable(disp_data_o));

   // R5: the fetched character index stays inside the message
   a_r5_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_len_i != '0) |-> (LW'(str_addr_o) < msg_len_i));
endmodule

bind scroll_text_engine scroll_text_engine_chk #(
   .ROWS (ROWS),
   .CW   (CW),
   .AW   (AW),
   .LW   (LW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .blank_i     (blank_i),
   .swap_o      (swap_o),
   .disp_col_i  (disp_col_i),
   .disp_data_o (disp_data_o),
   .str_addr_o  (str_addr_o),
   .msg_len_i   (msg_len_i)
);

// File: tb/scroll_text_engine_tb.sv
`timescale 1ns/1ps
module scroll_text_engine_tb;
   localparam int ROWS  = 8;
   localparam int COLS  = 16;
   localparam int DEPTH = 16;
   localparam int FW    = ROWS * COLS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          step = 1'b0;
   logic          blank = 1'b0;
   logic [4:0]    msg_len = 5'd1;
   logic [3:0]    str_addr;
   logic [7:0]    str_data;
   logic [3:0]    disp_col = '0;
   logic [ROWS-1:0] disp_data;
   logic          swap;

   logic [7:0]    msg_mem [DEPTH];
   logic [FW-1:0] expq [$];
   logic [FW-1:0] m_frame;
   int            m_ci, m_cc;
   int            checks = 0, failures = 0;
   bit            blank_en = 1'b1;
   bit            done = 1'b0;
   logic          prev_blank = 1'b0;
   int            bcnt = 0;

   assign str_data = msg_mem[str_addr];

   always #2 clk = ~clk;

   scroll_text_engine u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_i      (step),
      .blank_i     (blank),
      .msg_len_i   (msg_len),
      .str_addr_o  (str_addr),
      .str_data_i  (str_data),
      .disp_col_i  (disp_col),
      .disp_data_o (disp_data),
      .swap_o      (swap)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [FW-1:0] act, input logic [FW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // glyph columns as the requirements state them (R7, R8, R9, R4 gap)
   function automatic logic [6:0] spec_col(input logic [7:0] c, input int k);
      logic [6:0] g [5];
      if (k >= 5 || c < 8'h20 || c > 8'h7E) return 7'h00;
      case (c)
         8'h20:   g = '{default: 7'h00};
         8'h48:   g = '{7'h7F, 7'h08, 7'h08, 7'h08, 7'h7F};
         8'h49:   g = '{7'h00, 7'h41, 7'h7F, 7'h41, 7'h00};
         8'h31:   g = '{7'h00, 7'h42, 7'h7F, 7'h40, 7'h00};
         8'h2D:   g = '{default: 7'h08};
         default: g = '{7'h7F, 7'h41, 7'h41, 7'h41, 7'h7F};
      endcase
      return g[k];
   endfunction

   // driver side of the scoreboard: predict the next visible frame (R2, R4, R5)
   task automatic model_step();
      logic [ROWS-1:0] nc;
      nc = ROWS'(spec_col(msg_mem[m_ci], m_cc));
      m_frame = (m_frame >> ROWS) | (FW'(nc) << ((COLS-1)*ROWS));
      if (m_cc == 5) begin
         m_cc = 0;
         m_ci = (m_ci + 1 >= int'(msg_len)) ? 0 : m_ci + 1;
      end else begin
         m_cc++;
      end
      expq.push_back(m_frame);
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) model_step();
      @(posedge clk); #1 step = 1'b1;
      repeat (n) @(posedge clk);
      #1 step = 1'b0;
   endtask

   task automatic read_frame(output logic [FW-1:0] f);
      f = '0;
      for (int c = 0; c < COLS; c++) begin
         disp_col = 4'(c);
         #0.1;
         f[c*ROWS +: ROWS] = disp_data;
      end
   endtask

   task automatic wait_done();
      for (int i = 0; i < 80; i++) begin
         if (expq.size() == 0) break;
         @(negedge clk);
      end
      chk(expq.size() == 0, "R6", "every step produced a frame",
          FW'(expq.size()), '0);
      expq.delete();
      repeat (3) @(negedge clk);
      chk(int'(str_addr) == m_ci, "R5", "str_addr_o", FW'(str_addr), FW'(m_ci));
   endtask

   task automatic do_reset(input logic [4:0] len);
      rst_n = 1'b0;
      step  = 1'b0;
      msg_len = len;
      m_frame = '0;
      m_ci = 0;
      m_cc = 0;
      expq.delete();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // blanking generator: 2 of every 8 cycles
   always @(posedge clk) begin
      #1;
      bcnt++;
      blank = blank_en && ((bcnt % 8) >= 6);
   end

   // monitor side of the scoreboard
   always @(negedge clk) begin
      logic          b_now;
      logic [FW-1:0] got;
      b_now = blank;
      if (rst_n && swap) begin
         chk(prev_blank == 1'b1, "R3", "swap outside blanking", FW'(prev_blank), FW'(1));
         read_frame(got);
         if (expq.size() == 0) begin
            chk(1'b0, "R6", "swap with no step pending", got, '0);
         end else begin
            chk(got == expq[0], "R2", "visible frame after swap", got, expq[0]);
            void'(expq.pop_front());
         end
      end
      prev_blank = b_now;
   end

   initial begin
      logic [FW-1:0] f0, f1;
      for (int i = 0; i < DEPTH; i++) msg_mem[i] = 8'h20;

      // R1: reset state
      msg_mem[0] = 8'h48;
      msg_mem[1] = 8'h49;
      rst_n = 1'b0;
      msg_len = 5'd2;
      repeat (2) @(negedge clk);
      read_frame(f0);
      chk(f0 == '0, "R1", "frame during reset", f0, '0);
      do_reset(5'd2);
      @(negedge clk);
      read_frame(f0);
      chk(f0 == '0, "R1", "frame after reset", f0, '0);
      chk(swap == 1'b0, "R1", "swap_o after reset", FW'(swap), '0);
      chk(str_addr == 4'd0, "R1", "str_addr_o after reset", FW'(str_addr), '0);

      // R2, R4, R5, R7: "HI" scrolled past its wrap point
      for (int s = 0; s < 14; s++) begin
         tick(1);
         wait_done();
      end

      // R6: back-to-back ticks, and a tick arriving during the wait
      tick(2);
      wait_done();
      tick(1);
      tick(1);
      wait_done();
      tick(2);
      wait_done();

      // R3: no blanking, so the frame must hold and the step stays queued
      blank_en = 1'b0;
      repeat (3) @(negedge clk);
      read_frame(f0);
      tick(1);
      repeat (20) @(negedge clk);
      read_frame(f1);
      chk(f1 == f0, "R3", "frame held without blanking", f1, f0);
      chk(expq.size() == 1, "R3", "no swap without blanking", FW'(expq.size()), FW'(1));
      blank_en = 1'b1;
      wait_done();

      // R7, R8, R9: built-in, fallback-box and nonprintable codes with wrap
      msg_mem[0] = 8'h31;
      msg_mem[1] = 8'h2D;
      msg_mem[2] = 8'h07;
      msg_mem[3] = 8'h5A;
      msg_mem[4] = 8'h80;
      msg_mem[5] = 8'h20;
      do_reset(5'd6);
      for (int s = 0; s < 40; s++) begin
         tick(1);
         wait_done();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule